// File: doc/BRIEF.md
# Write Strobe Lane Generator

This block sits in the write path of a burst-capable bus master. For every beat an external address sequencer presents, it works out which byte lanes of the write data bus carry that beat's bytes. It returns a strobe mask with one bit per lane and the lane offset at which the beat's data must be placed. The data bus width is a build-time parameter. The beat size arrives with each beat as a log2 byte-count code.

Narrow beats move from lane to lane as the address advances. An unaligned first beat enables only the bytes from its start address up to the next beat boundary. A burst that repeats one address gets the same lanes on every beat. The decode is combinational from the address and size. It is captured in one register stage, so the mask and offset leave in the same cycle as the beat data that the master registers beside them. A size code wider than the bus is flagged and yields an empty mask.

Top module: `strb_lane_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `lane_vld`, `size_bad`, `lane_strb` and `lane_ofs` are all zero.
- R2: Outputs appear exactly one clock after the beat is presented: a beat accepted at edge N (with `beat_vld`=1) sets `lane_vld`=1 after edge N and not before.
- R3: For a legal beat, the lowest set bit of `lane_strb` is lane `beat_addr mod BUS_BYTES`.
- R4: For a legal beat, `lane_strb` has exactly `2^beat_size - (beat_addr mod 2^beat_size)` bits set.
- R5: The set lanes are contiguous and end at lane `lane_ofs + 2^beat_size - 1`, so a beat never spills past its own aligned boundary.
- R6: `lane_ofs` equals `beat_addr mod BUS_BYTES` with its low `beat_size` bits cleared (the lane of the beat's aligned start).
- R7: A `beat_size` code greater than log2(BUS_BYTES) sets `size_bad`=1 and gives `lane_strb`=0 and `lane_ofs`=0.
- R8: A cycle with `beat_vld`=0 gives `lane_vld`=0, `lane_strb`=0, `lane_ofs`=0 and `size_bad`=0 one clock later.
- R9: A beat whose size equals the bus width at an aligned address enables every lane.
- R10: Address bits at or above log2(BUS_BYTES) have no effect on the outputs, so repeating the same low address bits (a fixed burst) gives identical lanes on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_vld | input | 1 | A beat is presented this cycle |
| beat_addr | input | ADDR_W | Byte address of the beat |
| beat_size | input | 3 | log2 of the beat byte count (0 = 1 byte … 7 = 128 bytes) |
| lane_vld | output | 1 | Registered outputs belong to a beat |
| lane_strb | output | BUS_BYTES | Byte-lane strobe, bit i = lane i holds valid data |
| lane_ofs | output | log2(BUS_BYTES) | Lane of the beat's aligned start |
| size_bad | output | 1 | Beat size exceeds the bus width |

## Verification
The bench walks single-byte beats across every lane of the 8-byte bus. A decoder that ignored the address would repeat lane 0. One that used the size as a byte count would light several lanes. Half-width beats at 0x04 then 0x08 must swap between the upper and lower four lanes. Unaligned starts at 0x07 and 0x05 must clip at the beat boundary. A design that counted the full beat from the start address would spill past the top lane, or wrap to the low lanes. A repeated address with different upper bits must give identical masks. The oversized size codes 4 to 7 must give an empty mask. A design that truncated the size code would instead return a full or partial mask.

// File: rtl/strb_lane_pkg.sv
package strb_lane_pkg;

    localparam int unsigned SIZE_W = 3;

    typedef logic [SIZE_W-1:0] size_code_t;

    typedef enum logic [SIZE_W-1:0] {
        SZ_1B   = 3'd0,
        SZ_2B   = 3'd1,
        SZ_4B   = 3'd2,
        SZ_8B   = 3'd3,
        SZ_16B  = 3'd4,
        SZ_32B  = 3'd5,
        SZ_64B  = 3'd6,
        SZ_128B = 3'd7
    } beat_size_e;

    // Number of lane-index bits for a bus of the given byte width.
    function automatic int unsigned lane_bits(input int unsigned bus_bytes);
        return $clog2(bus_bytes);
    endfunction

    // A size code is legal when the beat fits within the bus.
    function automatic logic size_fits(input size_code_t code, input int unsigned lw);
        return int'(code) <= int'(lw);
    endfunction

endpackage

// File: rtl/strb_beat_align.sv
module strb_beat_align
    import strb_lane_pkg::*;
#(
    parameter int unsigned LANE_W = 3
) (
    input  logic [LANE_W-1:0] lane_addr,
    input  size_code_t        size,
    output logic [LANE_W-1:0] beat_base,
    output logic [LANE_W-1:0] beat_top,
    output logic              size_bad
);

    // Bits below the beat size: misalignment field within the beat.
    logic [LANE_W-1:0] low_mask;

    generate
        for (genvar j = 0; j < int'(LANE_W); j++) begin : g_low
            assign low_mask[j] = (size > SIZE_W'(j));
        end
    endgenerate

    assign size_bad  = !size_fits(size, LANE_W);
    assign beat_base = lane_addr & ~low_mask;
    assign beat_top  = beat_base | low_mask;

endmodule

// File: rtl/strb_lane_mask.sv
module strb_lane_mask #(
    parameter int unsigned BUS_BYTES = 8,
    parameter int unsigned LANE_W    = 3
) (
    input  logic [LANE_W-1:0]    lane_addr,
    input  logic [LANE_W-1:0]    beat_top,
    input  logic                 size_bad,
    output logic [BUS_BYTES-1:0] mask
);

    // Each lane enables itself when it lies between the start byte
    // and the last byte of the aligned beat window.
    generate
        for (genvar i = 0; i < int'(BUS_BYTES); i++) begin : g_lane
            localparam logic [LANE_W-1:0] IDX = LANE_W'(i);
            assign mask[i] = !size_bad && (IDX >= lane_addr) && (IDX <= beat_top);
        end
    endgenerate

endmodule

// File: rtl/strb_beat_reg.sv
module strb_beat_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_vld,
    input  logic [W-1:0] d,
    output logic         q_vld,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q     <= '0;
        end else begin
            q_vld <= d_vld;
            q     <= d_vld ? d : '0;
        end
    end

endmodule

// File: rtl/strb_lane_gen.sv
module strb_lane_gen
    import strb_lane_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8,
    localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 beat_vld,
    input  logic [ADDR_W-1:0]    beat_addr,
    input  logic [2:0]           beat_size,
    output logic                 lane_vld,
    output logic [BUS_BYTES-1:0] lane_strb,
    output logic [LANE_W-1:0]    lane_ofs,
    output logic                 size_bad
);

    typedef struct packed {
        logic                 bad;
        logic [LANE_W-1:0]    ofs;
        logic [BUS_BYTES-1:0] strb;
    } lane_beat_t;

    localparam int unsigned BEAT_W = $bits(lane_beat_t);

    logic [LANE_W-1:0]    lane_addr;
    logic [LANE_W-1:0]    beat_base;
    logic [LANE_W-1:0]    beat_top;
    logic                 bad_c;
    logic [BUS_BYTES-1:0] mask_c;
    lane_beat_t           beat_d;
    lane_beat_t           beat_q;
    logic                 unused_hi_addr;

    assign lane_addr      = beat_addr[LANE_W-1:0];
    assign unused_hi_addr = ^beat_addr[ADDR_W-1:LANE_W];

    strb_beat_align #(.LANE_W(LANE_W)) u_align (
        .lane_addr (lane_addr),
        .size      (size_code_t'(beat_size)),
        .beat_base (beat_base),
        .beat_top  (beat_top),
        .size_bad  (bad_c)
    );

    strb_lane_mask #(.BUS_BYTES(BUS_BYTES), .LANE_W(LANE_W)) u_mask (
        .lane_addr (lane_addr),
        .beat_top  (beat_top),
        .size_bad  (bad_c),
        .mask      (mask_c)
    );

    always_comb begin
        beat_d.bad  = bad_c;
        beat_d.ofs  = bad_c ? '0 : beat_base;
        beat_d.strb = mask_c;
    end

    strb_beat_reg #(.W(BEAT_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .d_vld (beat_vld),
        .d     (beat_d),
        .q_vld (lane_vld),
        .q     (beat_q)
    );

    assign lane_strb = beat_q.strb;
    assign lane_ofs  = beat_q.ofs;
    assign size_bad  = beat_q.bad;

endmodule

// File: rtl/strb_lane_gen_chk.sv
module strb_lane_gen_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8,
    localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 beat_vld,
    input logic [ADDR_W-1:0]    beat_addr,
    input logic [2:0]           beat_size,
    input logic                 lane_vld,
    input logic [BUS_BYTES-1:0] lane_strb,
    input logic [LANE_W-1:0]    lane_ofs,
    input logic                 size_bad
);

    logic [LANE_W-1:0]    prev_lo;
    logic [2:0]           prev_size;
    logic [BUS_BYTES-1:0] below_lo;
    int                   exp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lo   <= '0;
            prev_size <= '0;
        end else begin
            prev_lo   <= beat_addr[LANE_W-1:0];
            prev_size <= beat_size;
        end
    end

    always_comb begin
        for (int k = 0; k < int'(BUS_BYTES); k++) below_lo[k] = (k < int'(prev_lo));
        exp_cnt = (1 << prev_size) - (int'(prev_lo) % (1 << prev_size));
    end

    // R2: a beat shows up on the outputs one clock later
    a_r2_vld_follow: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !rst) |=> lane_vld);

    // R8: idle cycles leave everything quiet
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !lane_vld |-> (lane_strb == '0 && lane_ofs == '0 && !size_bad));

    // R7: oversized beats carry no lanes
    a_r7_bad_empty: assert property (@(posedge clk) disable iff (rst)
        size_bad |-> (lane_strb == '0 && lane_ofs == '0));

    // R7: flag matches the size presented one clock before
    a_r7_bad_flag: assert property (@(posedge clk) disable iff (rst)
        lane_vld |-> (size_bad == (int'(prev_size) > int'(LANE_W))));

    // R4: lane count = beat bytes minus misalignment
    a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
        (lane_vld && !size_bad) |-> ($countones(lane_strb) == exp_cnt));

    // R3: lowest lane is the start byte
    a_r3_low_lane: assert property (@(posedge clk) disable iff (rst)
        (lane_vld && !size_bad) |-> (lane_strb[prev_lo] && (lane_strb & below_lo) == '0));

endmodule

bind strb_lane_gen strb_lane_gen_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .beat_vld  (beat_vld),
    .beat_addr (beat_addr),
    .beat_size (beat_size),
    .lane_vld  (lane_vld),
    .lane_strb (lane_strb),
    .lane_ofs  (lane_ofs),
    .size_bad  (size_bad)
);

// File: tb/sim_strb_lane_gen.sv
`timescale 1ns/1ps
module sim_strb_lane_gen;
    import strb_lane_pkg::*;

    localparam int AW  = 16;
    localparam int BUS = 8;
    localparam int LW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           beat_vld = 1'b0;
    logic [AW-1:0]  beat_addr = '0;
    logic [2:0]     beat_size = '0;
    logic           lane_vld;
    logic [BUS-1:0] lane_strb;
    logic [LW-1:0]  lane_ofs;
    logic           size_bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    strb_lane_gen #(.ADDR_W(AW), .BUS_BYTES(BUS)) u0 (
        .clk(clk), .rst(rst), .beat_vld(beat_vld), .beat_addr(beat_addr),
        .beat_size(beat_size), .lane_vld(lane_vld), .lane_strb(lane_strb),
        .lane_ofs(lane_ofs), .size_bad(size_bad)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Byte-walk model: mark every byte from the start to the end of its aligned beat.
    function automatic logic [BUS-1:0] model_strb(input int a, input int sz);
        logic [BUS-1:0] m = '0;
        int bytes, base;
        if (sz > LW) return '0;
        bytes = 1 << sz;
        base  = a - (a % bytes);
        for (int b = a; b < base + bytes; b++) m[b % BUS] = 1'b1;
        return m;
    endfunction

    function automatic int model_ofs(input int a, input int sz);
        int bytes;
        if (sz > LW) return 0;
        bytes = 1 << sz;
        return (a - (a % bytes)) % BUS;
    endfunction

    // Called at a negedge; presents a beat and checks it at the following negedge.
    task automatic beat(input string req, input int a, input int sz);
        beat_vld  = 1'b1;
        beat_addr = AW'(a);
        beat_size = 3'(sz);
        @(negedge clk);
        check(req, "lane_vld", 32'(lane_vld), 32'd1);
        check(req, "lane_strb", 32'(lane_strb), 32'(model_strb(a, sz)));
        check(req, "lane_ofs", 32'(lane_ofs), 32'(model_ofs(a, sz)));
        check(req, "size_bad", 32'(size_bad), 32'(sz > LW));
    endtask

    task automatic idle(input string req);
        beat_vld  = 1'b0;
        beat_addr = 16'h00F5;
        beat_size = 3'(SZ_2B);
        @(negedge clk);
        check(req, "idle lane_vld", 32'(lane_vld), 32'd0);
        check(req, "idle lane_strb", 32'(lane_strb), 32'd0);
        check(req, "idle lane_ofs", 32'(lane_ofs), 32'd0);
        check(req, "idle size_bad", 32'(size_bad), 32'd0);
    endtask

    task automatic t_reset();
        beat_vld  = 1'b1;
        beat_addr = 16'h0003;
        beat_size = 3'(SZ_1B);
        repeat (3) @(negedge clk);
        check("R1", "reset lane_vld", 32'(lane_vld), 32'd0);
        check("R1", "reset lane_strb", 32'(lane_strb), 32'd0);
        check("R1", "reset lane_ofs", 32'(lane_ofs), 32'd0);
        check("R1", "reset size_bad", 32'(size_bad), 32'd0);
        beat_vld = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", "post-reset lane_vld", 32'(lane_vld), 32'd0);
        check("R1", "post-reset lane_strb", 32'(lane_strb), 32'd0);
    endtask

    task automatic t_latency();
        idle("R8");
        beat_vld  = 1'b1;
        beat_addr = 16'h0002;
        beat_size = 3'(SZ_2B);
        #2;
        check("R2", "no output before edge", 32'(lane_vld), 32'd0);
        @(negedge clk);
        check("R2", "output after one edge", 32'(lane_vld), 32'd1);
        check("R2", "strb after one edge", 32'(lane_strb), 32'h0C);
    endtask

    task automatic t_narrow_walk();
        for (int a = 0; a < 2 * BUS; a++) begin
            beat("R3", a, int'(SZ_1B));
            check("R3", "single lane", 32'(lane_strb), 32'(1) << (a % BUS));
        end
    endtask

    task automatic t_half_beats();
        beat("R6", 16'h0004, int'(SZ_4B));
        check("R6", "upper half", 32'(lane_strb), 32'hF0);
        check("R6", "upper ofs", 32'(lane_ofs), 32'd4);
        beat("R6", 16'h0008, int'(SZ_4B));
        check("R6", "lower half", 32'(lane_strb), 32'h0F);
        check("R6", "lower ofs", 32'(lane_ofs), 32'd0);
        beat("R6", 16'h000E, int'(SZ_2B));
        check("R6", "2-byte top", 32'(lane_strb), 32'hC0);
    endtask

    task automatic t_unaligned();
        beat("R5", 16'h0007, int'(SZ_4B));
        check("R5", "clip at beat end", 32'(lane_strb), 32'h80);
        check("R4", "clip ofs", 32'(lane_ofs), 32'd4);
        beat("R5", 16'h0008, int'(SZ_4B));
        check("R5", "next aligned", 32'(lane_strb), 32'h0F);
        beat("R4", 16'h0005, int'(SZ_8B));
        check("R4", "3 of 8 lanes", 32'(lane_strb), 32'hE0);
        beat("R4", 16'h0003, int'(SZ_2B));
        check("R4", "odd 2-byte", 32'(lane_strb), 32'h08);
    endtask

    task automatic t_full();
        beat("R9", 16'h0040, int'(SZ_8B));
        check("R9", "all lanes", 32'(lane_strb), 32'hFF);
    endtask

    task automatic t_fixed();
        for (int k = 0; k < 3; k++) begin
            beat("R10", 16'h0013, int'(SZ_2B));
            check("R10", "fixed lanes", 32'(lane_strb), 32'h08);
            check("R10", "fixed ofs", 32'(lane_ofs), 32'd2);
        end
        beat("R10", 16'hA5D3, int'(SZ_2B));
        check("R10", "upper bits ignored", 32'(lane_strb), 32'h08);
    endtask

    task automatic t_illegal();
        for (int sz = 4; sz < 8; sz++) begin
            beat("R7", 16'h0006, sz);
            check("R7", "bad flag", 32'(size_bad), 32'd1);
            check("R7", "empty mask", 32'(lane_strb), 32'd0);
        end
        idle("R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_narrow_walk();
        t_half_beats();
        t_unaligned();
        t_full();
        t_fixed();
        t_illegal();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule